// File: doc/BRIEF.md
# Raster scanout engine with half-turn rotation

This block feeds a fixed-resolution true-colour display from a framebuffer in external memory. Software programs a base address and a control word through a two-entry register port. While enabled, the engine walks the visible raster. For each pixel it computes one word address and issues a single read, waiting for the data before it asks for the next word. It splits each returned word into 8-bit red, green and blue values and presents them with a one-cycle pixel strobe. The first pixel of each frame carries a start-of-frame flag.

Each row occupies a fixed stride of words in memory, and only the leading visible words of a row are fetched. The framebuffer base keeps only its upper bits, so the buffer sits on a large aligned boundary. A rotate bit reverses the scan in both axes, which turns the picture through a half turn. The base and the rotate bit are captured only when a frame begins. Software can therefore reprogram them at any time without tearing the frame being shown. Clearing the enable bit stops all reads, abandons the frame in progress and holds the colour outputs at zero.

Top module: `fb_scanout`

## Requirements
- R1: After reset, mem_req and pix_valid are low, the colour outputs are zero, and both registers read back zero.
- R2: A write with reg_idx=0 sets the base address. Only its upper BASE_KEEP bits (11 by default) are stored. The lower 21 bits read back, and are used, as zero.
- R3: A write with reg_idx=1 sets the control word. Bit 0 is enable and bit 1 is rotate. Readback returns those two bits, with bits 31:2 always zero.
- R4: Unrotated, pixels are fetched in raster order with the column varying fastest. The pixel at column x, row y has byte address base + (y*ROW_STRIDE + x)*4, and only the first H_VIS words of each row are read.
- R5: With rotate set, the pixel shown at (x, y) is fetched from column H_VIS-1-x and row V_VIS-1-y.
- R6: One cycle after mem_rvalid, pix_valid pulses high with red = data[23:16], green = data[15:8] and blue = data[7:0]. Bits 31:24 have no effect.
- R7: While enable is clear, no read is requested and no pixel is strobed. Clearing enable mid-frame abandons that frame. Setting it again restarts the scan at pixel (0,0).
- R8: Writes to base or rotate during a frame do not alter that frame. They apply from the next frame onward.
- R9: mem_req stays high with mem_addr stable until mem_gnt. At most one read is outstanding, and no new request is made until its mem_rvalid.
- R10: pix_sof is high together with pix_valid exactly for pixel (0,0) of each frame.
- R11: The colour outputs are zero in every cycle where pix_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_idx | input | 1 | Register select: 0 base, 1 control |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Readback of the selected register |
| mem_req | output | 1 | Read request, held until granted |
| mem_addr | output | 32 | Byte address of the requested word |
| mem_gnt | input | 1 | Request accepted |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data word |
| pix_valid | output | 1 | Pixel strobe |
| pix_sof | output | 1 | First pixel of a frame |
| pix_r | output | 8 | Red level |
| pix_g | output | 8 | Green level |
| pix_b | output | 8 | Blue level |

## Verification
The bench builds the block with a 4-by-3 visible raster and a row stride of 8 words, which makes a frame 12 pixels long. At that size every address and every pixel of several whole frames can be checked. The run covers an unrotated frame, a rotated frame and a frame at a new base, then a restart after a mid-frame disable. The small stride keeps the skipped words at the end of each row close enough to reveal an address that strays into them. Grant delays and read latencies vary from request to request, so the one-outstanding handshake is exercised under both stall and back-to-back conditions.

// File: rtl/fb_pkg.sv
package fb_pkg;

  localparam int FB_AW = 32;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } scan_state_e;

  typedef struct packed {
    logic [7:0] r;
    logic [7:0] g;
    logic [7:0] b;
  } rgb_t;

  // byte address of a word at (col,row) for a given word stride
  function automatic logic [FB_AW-1:0] fb_word_addr(
    input logic [FB_AW-1:0] base,
    input logic [FB_AW-1:0] col,
    input logic [FB_AW-1:0] row,
    input logic [FB_AW-1:0] stride
  );
    logic [FB_AW-1:0] widx;
    widx = row * stride + col;
    return base + (widx << 2);
  endfunction

  // colour split of a memory word; top byte carries no colour
  function automatic rgb_t fb_split_word(input logic [31:0] w);
    rgb_t c;
    c.r = w[23:16];
    c.g = w[15:8];
    c.b = w[7:0];
    return c;
  endfunction

endpackage

// File: rtl/fb_regs.sv
module fb_regs #(
  parameter int BASE_KEEP = 11
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we,
  input  logic        idx,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic [31:0] base,
  output logic        en,
  output logic        rot
);
  localparam int DROP = 32 - BASE_KEEP;

  logic [BASE_KEEP-1:0] base_q;
  logic                 en_q;
  logic                 rot_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      en_q   <= 1'b0;
      rot_q  <= 1'b0;
    end else if (we) begin
      if (!idx) begin
        base_q <= wdata[31:DROP];
      end else begin
        en_q  <= wdata[0];
        rot_q <= wdata[1];
      end
    end
  end

  assign base  = {base_q, {DROP{1'b0}}};
  assign en    = en_q;
  assign rot   = rot_q;
  assign rdata = idx ? {30'd0, rot_q, en_q} : base;

  logic unused_wbits;
  assign unused_wbits = ^{wdata[DROP-1:2]};

  // R3
  ctrl_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idx |-> (rdata[31:2] == 30'd0));

  // R3
  ctrl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && idx) |=> (en == $past(wdata[0]) && rot == $past(wdata[1])));

  // R2
  base_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !idx |-> (rdata[DROP-1:0] == '0));

endmodule

// File: rtl/fb_raster.sv
module fb_raster #(
  parameter int H_VIS = 640,
  parameter int V_VIS = 480,
  localparam int X_W = (H_VIS > 1) ? $clog2(H_VIS) : 1,
  localparam int Y_W = (V_VIS > 1) ? $clog2(V_VIS) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic           step,
  output logic [X_W-1:0] x,
  output logic [Y_W-1:0] y,
  output logic           first,
  output logic           last
);
  localparam logic [X_W-1:0] X_LAST = X_W'(H_VIS - 1);
  localparam logic [Y_W-1:0] Y_LAST = Y_W'(V_VIS - 1);

  logic [X_W-1:0] x_q;
  logic [Y_W-1:0] y_q;
  logic           x_end;

  assign x_end = (x_q == X_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      x_q <= '0;
      y_q <= '0;
    end else if (step) begin
      if (x_end) begin
        x_q <= '0;
        y_q <= (y_q == Y_LAST) ? '0 : y_q + 1'b1;
      end else begin
        x_q <= x_q + 1'b1;
      end
    end
  end

  assign x     = x_q;
  assign y     = y_q;
  assign first = (x_q == '0) && (y_q == '0);
  assign last  = x_end && (y_q == Y_LAST);

  // R4
  col_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (x_q <= X_LAST) && (y_q <= Y_LAST));

  // R4
  col_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clr && !x_end) |=> (x_q == $past(x_q) + 1'b1) && $stable(y_q));

endmodule

// File: rtl/fb_addr_gen.sv
module fb_addr_gen
  import fb_pkg::*;
#(
  parameter int H_VIS      = 640,
  parameter int V_VIS      = 480,
  parameter int ROW_STRIDE = 1024,
  localparam int X_W = (H_VIS > 1) ? $clog2(H_VIS) : 1,
  localparam int Y_W = (V_VIS > 1) ? $clog2(V_VIS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [FB_AW-1:0] base_in,
  input  logic             rot_in,
  input  logic [X_W-1:0]   x,
  input  logic [Y_W-1:0]   y,
  output logic [FB_AW-1:0] addr
);
  localparam logic [X_W-1:0]   X_LAST      = X_W'(H_VIS - 1);
  localparam logic [Y_W-1:0]   Y_LAST      = Y_W'(V_VIS - 1);
  localparam logic [FB_AW-1:0] FRAME_BYTES = FB_AW'(ROW_STRIDE * V_VIS * 4);

  logic [FB_AW-1:0] base_q;
  logic             rot_q;
  logic [X_W-1:0]   src_col;
  logic [Y_W-1:0]   src_row;

  // frame-start shadow so mid-frame writes never tear a frame
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      rot_q  <= 1'b0;
    end else if (load) begin
      base_q <= base_in;
      rot_q  <= rot_in;
    end
  end

  assign src_col = rot_q ? (X_LAST - x) : x;
  assign src_row = rot_q ? (Y_LAST - y) : y;
  assign addr    = fb_word_addr(base_q, FB_AW'(src_col), FB_AW'(src_row),
                                FB_AW'(ROW_STRIDE));

  // R4
  addr_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((addr - base_q) < FRAME_BYTES) && (addr[1:0] == 2'b00));

  // R8
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(base_q) && $stable(rot_q)));

endmodule

// File: rtl/fb_pix_out.sv
module fb_pix_out
  import fb_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        take,
  input  logic        first,
  input  logic [31:0] word,
  output logic        pix_valid,
  output logic        pix_sof,
  output logic [7:0]  pix_r,
  output logic [7:0]  pix_g,
  output logic [7:0]  pix_b
);
  rgb_t colour_q;
  logic valid_q;
  logic sof_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q  <= 1'b0;
      sof_q    <= 1'b0;
      colour_q <= '0;
    end else begin
      valid_q  <= take;
      sof_q    <= take && first;
      colour_q <= take ? fb_split_word(word) : '0;
    end
  end

  assign pix_valid = valid_q;
  assign pix_sof   = sof_q;
  assign pix_r     = colour_q.r;
  assign pix_g     = colour_q.g;
  assign pix_b     = colour_q.b;

  // R6
  strobe_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> $past(take));

  // R11
  blank_colour_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_q |-> (colour_q == '0));

endmodule

// File: rtl/fb_scanout.sv
module fb_scanout
  import fb_pkg::*;
#(
  parameter int H_VIS      = 640,
  parameter int V_VIS      = 480,
  parameter int ROW_STRIDE = 1024,
  parameter int BASE_KEEP  = 11
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic        reg_idx,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mem_req,
  output logic [31:0] mem_addr,
  input  logic        mem_gnt,
  input  logic        mem_rvalid,
  input  logic [31:0] mem_rdata,
  output logic        pix_valid,
  output logic        pix_sof,
  output logic [7:0]  pix_r,
  output logic [7:0]  pix_g,
  output logic [7:0]  pix_b
);
  localparam int X_W = (H_VIS > 1) ? $clog2(H_VIS) : 1;
  localparam int Y_W = (V_VIS > 1) ? $clog2(V_VIS) : 1;

  scan_state_e    state_q;
  logic [31:0]    cfg_base;
  logic           ctl_en;
  logic           ctl_rot;
  logic [X_W-1:0] ras_x;
  logic [Y_W-1:0] ras_y;
  logic           ras_first;
  logic           ras_last;

  // named internal events
  logic frame_load;
  logic word_take;
  logic rd_busy;

  assign frame_load = (state_q == ST_IDLE) && ctl_en;
  assign word_take  = (state_q == ST_WAIT) && mem_rvalid && ctl_en;
  assign rd_busy    = (state_q == ST_WAIT);

  fb_regs #(.BASE_KEEP(BASE_KEEP)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (reg_we),
    .idx   (reg_idx),
    .wdata (reg_wdata),
    .rdata (reg_rdata),
    .base  (cfg_base),
    .en    (ctl_en),
    .rot   (ctl_rot)
  );

  fb_raster #(.H_VIS(H_VIS), .V_VIS(V_VIS)) u_raster (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (state_q == ST_IDLE),
    .step  (word_take),
    .x     (ras_x),
    .y     (ras_y),
    .first (ras_first),
    .last  (ras_last)
  );

  fb_addr_gen #(.H_VIS(H_VIS), .V_VIS(V_VIS), .ROW_STRIDE(ROW_STRIDE)) u_addr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (frame_load),
    .base_in (cfg_base),
    .rot_in  (ctl_rot),
    .x       (ras_x),
    .y       (ras_y),
    .addr    (mem_addr)
  );

  fb_pix_out u_pix (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (word_take),
    .first     (ras_first),
    .word      (mem_rdata),
    .pix_valid (pix_valid),
    .pix_sof   (pix_sof),
    .pix_r     (pix_r),
    .pix_g     (pix_g),
    .pix_b     (pix_b)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: if (ctl_en) state_q <= ST_REQ;
        ST_REQ: begin
          if (!ctl_en)      state_q <= ST_IDLE;
          else if (mem_gnt) state_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (mem_rvalid) state_q <= (ctl_en && !ras_last) ? ST_REQ : ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_req = (state_q == ST_REQ) && ctl_en;

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt) |=> (!mem_req || $stable(mem_addr)));

  // R9
  one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_gnt) |=> (rd_busy && !mem_req));

  // R7
  pix_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ctl_en) |-> !pix_valid);

  // R6
  pix_after_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |-> $past(mem_rvalid));

  // R10
  sof_with_pix_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_sof |-> pix_valid);

  // R7
  restart_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_load |=> ras_first);

endmodule

// File: tb/test_fb_scanout.sv
module test_fb_scanout;
  localparam int H  = 4;
  localparam int V  = 3;
  localparam int ST = 8;
  localparam int NPIX = H * V;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic        reg_idx = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_gnt = 1'b0;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        pix_valid, pix_sof;
  logic [7:0]  pix_r, pix_g, pix_b;

  always #2.5 clk = ~clk;

  fb_scanout #(.H_VIS(H), .V_VIS(V), .ROW_STRIDE(ST), .BASE_KEEP(11)) i_fb_scanout (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .pix_valid(pix_valid), .pix_sof(pix_sof),
    .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // bench model state
  logic [31:0] prog_base = '0;
  bit          prog_rot = 1'b0;
  logic [31:0] cur_base = '0;
  bit          cur_rot = 1'b0;
  int          gidx = 0;
  int          frame_no = 0;
  int          gcount = 0;
  bit          hold_gnt = 1'b0;
  int          pix_seen = 0;

  function automatic logic [31:0] exp_addr(input logic [31:0] b, input bit r,
                                           input int i);
    int x, y;
    x = i % H;
    y = i / H;
    if (r) begin
      x = H - 1 - x;
      y = V - 1 - y;
    end
    return b + 32'((y * ST + x) * 4);
  endfunction

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return {~a[7:0], a[9:2], a[31:24] ^ a[7:0], a[9:2] + 8'h35};
  endfunction

  // memory model and pixel monitor, all at the falling edge
  initial begin
    bit          pending = 1'b0;
    int          pend_left = 0;
    logic [31:0] pend_addr = '0;
    bit          pend_sof = 1'b0;
    bit          exp_pend = 1'b0;
    logic [31:0] exp_word = '0;
    bit          exp_sof = 1'b0;
    bit          req_seen = 1'b0;
    int          wait_left = 0;
    logic [31:0] held = '0;
    string       lab;
    forever begin
      @(negedge clk);
      // pixel side
      if (exp_pend) begin
        chk(pix_valid, "R6 strobe", {31'd0, pix_valid}, 32'd1);
        chk({pix_r, pix_g, pix_b} == exp_word[23:0], "R6 colour",
            {8'd0, pix_r, pix_g, pix_b}, {8'd0, exp_word[23:0]});
        chk(pix_sof == exp_sof, "R10 sof", {31'd0, pix_sof}, {31'd0, exp_sof});
        pix_seen++;
        exp_pend = 1'b0;
      end else begin
        chk(!pix_valid, "R6 stray strobe", {31'd0, pix_valid}, 32'd0);
        chk({pix_r, pix_g, pix_b} == 24'd0, "R11 blank colour",
            {8'd0, pix_r, pix_g, pix_b}, 32'd0);
      end
      // memory side
      mem_gnt = 1'b0;
      mem_rvalid = 1'b0;
      if (pending) begin
        pend_left--;
        if (pend_left == 0) begin
          pending = 1'b0;
          mem_rvalid = 1'b1;
          mem_rdata = mem_word(pend_addr);
          exp_pend = 1'b1;
          exp_word = mem_rdata;
          exp_sof = pend_sof;
        end
      end
      if (mem_req) begin
        if (pending || mem_rvalid)
          chk(1'b0, "R9 second outstanding", mem_addr, 32'd0);
        else if (!req_seen) begin
          req_seen = 1'b1;
          wait_left = gcount % 3;
          held = mem_addr;
        end else
          chk(mem_addr == held, "R9 addr held", mem_addr, held);
        if (req_seen && wait_left == 0 && !hold_gnt) begin
          mem_gnt = 1'b1;
          req_seen = 1'b0;
          if (gidx == 0) begin
            cur_base = prog_base;
            cur_rot = prog_rot;
          end
          if (gidx >= 6 && frame_no < 2) lab = "R8 address";
          else lab = cur_rot ? "R5 address" : "R4 address";
          chk(mem_addr == exp_addr(cur_base, cur_rot, gidx), lab, mem_addr,
              exp_addr(cur_base, cur_rot, gidx));
          pending = 1'b1;
          pend_left = 1 + ((gcount * 7) % 3);
          pend_addr = mem_addr;
          pend_sof = (gidx == 0);
          gcount++;
          gidx++;
          if (gidx == NPIX) begin
            gidx = 0;
            frame_no++;
          end
        end else if (wait_left > 0)
          wait_left--;
      end else
        req_seen = 1'b0;
    end
  end

  task automatic wr(input bit idx, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1;
    reg_idx = idx;
    reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_chk(input bit idx, input logic [31:0] exp, input string req);
    @(negedge clk);
    reg_idx = idx;
    #0.5;
    chk(reg_rdata == exp, req, reg_rdata, exp);
  endtask

  task automatic idle_chk(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(!mem_req && !pix_valid, req, {30'd0, mem_req, pix_valid}, 32'd0);
    end
  endtask

  initial begin
    repeat (5) @(negedge clk);
    // R1 reset state
    chk(!mem_req, "R1 mem_req", {31'd0, mem_req}, 32'd0);
    chk(!pix_valid, "R1 pix_valid", {31'd0, pix_valid}, 32'd0);
    rst_n = 1'b1;
    rd_chk(1'b0, 32'd0, "R1 base reset");
    rd_chk(1'b1, 32'd0, "R1 ctrl reset");

    // R2 base truncation
    wr(1'b0, 32'h1234_5678);
    rd_chk(1'b0, 32'h1220_0000, "R2 base readback");
    prog_base = 32'h1220_0000;

    // R3 control readback, unused bits dropped
    wr(1'b1, 32'hFFFF_FFFC);
    rd_chk(1'b1, 32'd0, "R3 ctrl upper bits");
    wr(1'b1, 32'h0000_0002);
    rd_chk(1'b1, 32'd2, "R3 ctrl rotate only");
    idle_chk(10, "R7 disabled no activity");

    // frame 0 unrotated; rotate written mid-frame (R8)
    wr(1'b1, 32'h0000_0001);
    prog_rot = 1'b0;
    while (pix_seen < 5) @(negedge clk);
    wr(1'b1, 32'h0000_0003);
    prog_rot = 1'b1;
    rd_chk(1'b1, 32'd3, "R3 ctrl enable+rotate");
    // frame 1 rotated; base changed mid-frame (R8)
    while (pix_seen < NPIX + 5) @(negedge clk);
    wr(1'b0, 32'hFFFF_FFFF);
    prog_base = 32'hFFE0_0000;
    rd_chk(1'b0, 32'hFFE0_0000, "R2 base all ones");
    while (pix_seen < 3 * NPIX + 3) @(negedge clk);

    // R7 abandon a frame: stall the grant, then disable
    hold_gnt = 1'b1;
    while (!mem_req) @(negedge clk);
    wr(1'b1, 32'h0000_0000);
    idle_chk(12, "R7 disabled mid-frame");
    gidx = 0;
    hold_gnt = 1'b0;

    // restart unrotated at a new base: scan restarts at pixel 0 (R7, R10)
    wr(1'b0, 32'h0020_0000);
    prog_base = 32'h0020_0000;
    prog_rot = 1'b0;
    begin
      int start = pix_seen;
      wr(1'b1, 32'h0000_0001);
      while (pix_seen < start + NPIX + 2) @(negedge clk);
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", pix_seen, 5 * NPIX);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule